// File: doc/BRIEF.md
# PWM Action Generator with Fault Trip

This block turns the events of a shared up/down timebase into two PWM waveforms, A and B. Each cycle it looks at four events: a zero strobe, a period strobe, and two compare matches. Each compare match fires when the counter equals one of two compare values, and both outputs use the same two compare values. The event chosen in that cycle selects a two-bit action code for each output. The code is taken from a per-output table, and the table holds a separate code for each counting direction. The action then sets, clears, toggles or holds the output register.

Three fault inputs can override the timer events. Each fault has an enable and an active-level bit. Each fault can be routed to a one-shot trip, a cycle-by-cycle trip, or both. A one-shot trip is latched and stays until a clear pulse arrives. A cycle-by-cycle trip holds while the fault is present and until the next zero strobe. While a trip is in force, each output follows its own trip action code for the current counting direction.

Top module: `pwm_trip_gen`

## Requirements
- R1: While `rst_n` is low, `pwm_a`, `pwm_b`, `ost_active` and `cbc_active` are 0.
- R2: The action codes are 0 = hold, 1 = drive low, 2 = drive high and 3 = toggle. Outputs are registered: an action chosen from a cycle's inputs appears after the next rising edge. With no event and no trip, both outputs hold.
- R3: Event table layout: each 16-bit table is indexed by event number e (zero = 0, period = 1, compare A = 2, compare B = 3). Bits [4e+1:4e] hold the up-count code and bits [4e+3:4e+2] hold the down-count code. `cnt_up` = 1 selects the up-count code.
- R4: A compare event is raised when `cnt` equals `cmp_a` (or `cmp_b`). Both outputs respond to the same compare values, each through its own table.
- R5: When several timer events coincide, only one is used. The period event wins over zero, zero over compare B, and compare B over compare A.
- R6: Fault i is active when `flt_en[i]` = 1 and `fault_in[i]` equals `flt_pol[i]`. A disabled fault, or one at its inactive level, has no effect.
- R7: An active fault with its `ost_sel` bit set latches the one-shot trip, which `ost_active` reflects after the edge. The latch holds until a cycle with `ost_clr` = 1 and no such fault. If a fault and a clear arrive in the same cycle, the fault wins.
- R8: An active fault with its `cbc_sel` bit set applies the cycle-by-cycle trip. The trip stays latched (`cbc_active`) after the fault leaves, until a `tez` cycle with no such fault. In that cycle the zero action applies and the latch drops.
- R9: Each trip table is 4 bits per output: [1:0] is the up-count code and [3:2] is the down-count code. The one-shot trip wins over the cycle-by-cycle trip, and any trip wins over timer events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt | input | CNT_W | Timebase counter value |
| cnt_up | input | 1 | 1 = counting up, 0 = counting down |
| tez | input | 1 | Counter-at-zero strobe |
| tep | input | 1 | Counter-at-period strobe |
| cmp_a | input | CNT_W | Compare value A |
| cmp_b | input | CNT_W | Compare value B |
| fault_in | input | NFAULT | Fault pins |
| flt_en | input | NFAULT | Per-fault enable |
| flt_pol | input | NFAULT | Per-fault active level |
| ost_sel | input | NFAULT | Route fault to one-shot trip |
| cbc_sel | input | NFAULT | Route fault to cycle-by-cycle trip |
| ost_clr | input | 1 | One-shot trip clear |
| ev_act_a | input | 16 | Event action table, output A |
| ev_act_b | input | 16 | Event action table, output B |
| ost_act_a | input | 4 | One-shot trip actions, output A |
| ost_act_b | input | 4 | One-shot trip actions, output B |
| cbc_act_a | input | 4 | Cycle-by-cycle trip actions, output A |
| cbc_act_b | input | 4 | Cycle-by-cycle trip actions, output B |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| ost_active | output | 1 | One-shot trip latched |
| cbc_active | output | 1 | Cycle-by-cycle trip latched |

## Verification
The bench builds the block with its defaults: a 16-bit counter and three faults. With these, compare values such as 100, 150 and 200 can be placed freely. Every fault routing can be tried: one fault to the one-shot trip with active-low level, one to the cycle-by-cycle trip with active-high level, and one left disabled. Setting both compare values equal brings the compare-B-over-compare-A priority within reach. A zero strobe arriving while the cycle-by-cycle latch is held shows exactly in which cycle the trip releases.

// File: rtl/pwm_act_pkg.sv
package pwm_act_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  localparam int NUM_EV    = 4;
  localparam int EV_ZERO   = 0;
  localparam int EV_PERIOD = 1;
  localparam int EV_CMPA   = 2;
  localparam int EV_CMPB   = 3;
  localparam int EV_TBL_W  = NUM_EV * 4;

  // Next output level for an action code.
  function automatic logic act_apply(input logic cur, input logic [1:0] code);
    case (act_e'(code))
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  // Code for event ev and direction from a per-output event table.
  function automatic logic [1:0] ev_code(input logic [EV_TBL_W-1:0] tbl,
                                         input logic [1:0] ev, input logic up);
    int base;
    base = int'(ev) * 4 + (up ? 0 : 2);
    return tbl[base +: 2];
  endfunction

  // Code for a trip table (up in [1:0], down in [3:2]).
  function automatic logic [1:0] trip_code(input logic [3:0] tbl, input logic up);
    return up ? tbl[1:0] : tbl[3:2];
  endfunction
endpackage

// File: rtl/pwm_trip_ctl.sv
module pwm_trip_ctl #(
  parameter int NFAULT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFAULT-1:0] fault_in,
  input  logic [NFAULT-1:0] flt_en,
  input  logic [NFAULT-1:0] flt_pol,
  input  logic [NFAULT-1:0] ost_sel,
  input  logic [NFAULT-1:0] cbc_sel,
  input  logic              ost_clr,
  input  logic              tez,
  output logic              ost_hit,
  output logic              cbc_hit,
  output logic              ost_eff,
  output logic              cbc_eff,
  output logic              ost_q,
  output logic              cbc_q
);
  logic [NFAULT-1:0] flt_act;

  for (genvar i = 0; i < NFAULT; i++) begin : g_qual
    assign flt_act[i] = flt_en[i] & (fault_in[i] == flt_pol[i]);
  end

  assign ost_hit = |(flt_act & ost_sel);
  assign cbc_hit = |(flt_act & cbc_sel);
  assign ost_eff = ost_hit | ost_q;
  assign cbc_eff = cbc_hit | (cbc_q & ~tez);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ost_q <= 1'b0;
      cbc_q <= 1'b0;
    end else begin
      ost_q <= ost_hit | (ost_q & ~ost_clr);
      cbc_q <= cbc_hit | (cbc_q & ~tez);
    end
  end
endmodule

// File: rtl/pwm_evt_det.sv
module pwm_evt_det #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic             tez,
  input  logic             tep,
  output logic             any_ev,
  output logic [1:0]       sel_ev
);
  import pwm_act_pkg::*;

  logic hit_a, hit_b;
  assign hit_a  = (cnt == cmp_a);
  assign hit_b  = (cnt == cmp_b);
  assign any_ev = tez | tep | hit_a | hit_b;

  always_comb begin
    if (tep)        sel_ev = 2'(EV_PERIOD);
    else if (tez)   sel_ev = 2'(EV_ZERO);
    else if (hit_b) sel_ev = 2'(EV_CMPB);
    else            sel_ev = 2'(EV_CMPA);
  end
endmodule

// File: rtl/pwm_out_gen.sv
module pwm_out_gen
  import pwm_act_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_up,
  input  logic                any_ev,
  input  logic [1:0]          sel_ev,
  input  logic [EV_TBL_W-1:0] ev_tbl,
  input  logic                ost_eff,
  input  logic                cbc_eff,
  input  logic [3:0]          ost_tbl,
  input  logic [3:0]          cbc_tbl,
  output logic                pwm_q
);
  logic [1:0] code;

  always_comb begin
    if (ost_eff)      code = trip_code(ost_tbl, cnt_up);
    else if (cbc_eff) code = trip_code(cbc_tbl, cnt_up);
    else if (any_ev)  code = ev_code(ev_tbl, sel_ev, cnt_up);
    else              code = ACT_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= act_apply(pwm_q, code);
  end
endmodule

// File: rtl/pwm_trip_gen.sv
module pwm_trip_gen #(
  parameter int CNT_W  = 16,
  parameter int NFAULT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cnt_up,
  input  logic              tez,
  input  logic              tep,
  input  logic [CNT_W-1:0]  cmp_a,
  input  logic [CNT_W-1:0]  cmp_b,
  input  logic [NFAULT-1:0] fault_in,
  input  logic [NFAULT-1:0] flt_en,
  input  logic [NFAULT-1:0] flt_pol,
  input  logic [NFAULT-1:0] ost_sel,
  input  logic [NFAULT-1:0] cbc_sel,
  input  logic              ost_clr,
  input  logic [15:0]       ev_act_a,
  input  logic [15:0]       ev_act_b,
  input  logic [3:0]        ost_act_a,
  input  logic [3:0]        ost_act_b,
  input  logic [3:0]        cbc_act_a,
  input  logic [3:0]        cbc_act_b,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              ost_active,
  output logic              cbc_active
);
  localparam int NOUT = 2;

  logic       ost_hit, cbc_hit, ost_eff, cbc_eff;
  logic       any_ev;
  logic [1:0] sel_ev;

  logic [15:0]     ev_tbl  [NOUT];
  logic [3:0]      ost_tbl [NOUT];
  logic [3:0]      cbc_tbl [NOUT];
  logic [NOUT-1:0] pwm_vec;

  assign ev_tbl[0]  = ev_act_a;
  assign ev_tbl[1]  = ev_act_b;
  assign ost_tbl[0] = ost_act_a;
  assign ost_tbl[1] = ost_act_b;
  assign cbc_tbl[0] = cbc_act_a;
  assign cbc_tbl[1] = cbc_act_b;

  pwm_trip_ctl #(.NFAULT(NFAULT)) u_trip (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .flt_en(flt_en),
    .flt_pol(flt_pol), .ost_sel(ost_sel), .cbc_sel(cbc_sel),
    .ost_clr(ost_clr), .tez(tez), .ost_hit(ost_hit), .cbc_hit(cbc_hit),
    .ost_eff(ost_eff), .cbc_eff(cbc_eff), .ost_q(ost_active), .cbc_q(cbc_active)
  );

  pwm_evt_det #(.CNT_W(CNT_W)) u_evt (
    .cnt(cnt), .cmp_a(cmp_a), .cmp_b(cmp_b), .tez(tez), .tep(tep),
    .any_ev(any_ev), .sel_ev(sel_ev)
  );

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    pwm_out_gen u_gen (
      .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .any_ev(any_ev),
      .sel_ev(sel_ev), .ev_tbl(ev_tbl[k]), .ost_eff(ost_eff),
      .cbc_eff(cbc_eff), .ost_tbl(ost_tbl[k]), .cbc_tbl(cbc_tbl[k]),
      .pwm_q(pwm_vec[k])
    );
  end

  assign pwm_a = pwm_vec[0];
  assign pwm_b = pwm_vec[1];
endmodule

// File: rtl/pwm_trip_gen_chk.sv
module pwm_trip_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_up,
  input logic       tez,
  input logic       ost_clr,
  input logic       ost_hit,
  input logic       cbc_hit,
  input logic       ost_eff,
  input logic       cbc_eff,
  input logic       any_ev,
  input logic [3:0] ost_act_a,
  input logic       ost_active,
  input logic       cbc_active,
  input logic       pwm_a
);
  // R7: a qualifying fault sets the one-shot latch.
  a_r7_ost_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ost_hit |=> ost_active);

  // R7: without a clear the one-shot latch holds.
  a_r7_ost_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ost_active && !ost_clr |=> ost_active);

  // R8: the cycle-by-cycle latch follows its fault.
  a_r8_cbc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cbc_hit |=> cbc_active);

  // R8: a zero strobe with no fault releases the cycle-by-cycle latch.
  a_r8_cbc_release: assert property (@(posedge clk) disable iff (!rst_n)
    cbc_active && tez && !cbc_hit |=> !cbc_active);

  // R9: a one-shot force-high on the up count drives output A high.
  a_r9_ost_force: assert property (@(posedge clk) disable iff (!rst_n)
    ost_eff && cnt_up && (ost_act_a[1:0] == 2'd2) |=> pwm_a);

  // R2: no event and no trip means the output holds.
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ev && !ost_eff && !cbc_eff |=> $stable(pwm_a));
endmodule

bind pwm_trip_gen pwm_trip_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .tez(tez), .ost_clr(ost_clr),
  .ost_hit(ost_hit), .cbc_hit(cbc_hit), .ost_eff(ost_eff), .cbc_eff(cbc_eff),
  .any_ev(any_ev), .ost_act_a(ost_act_a), .ost_active(ost_active),
  .cbc_active(cbc_active), .pwm_a(pwm_a)
);

// File: tb/pwm_trip_gen_tb.sv
module pwm_trip_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        cnt_up = 1'b1, tez = 1'b0, tep = 1'b0;
  logic [15:0] cmp_a = 16'd100, cmp_b = 16'd200;
  logic [2:0]  fault_in = '0, flt_en = '0, flt_pol = '0, ost_sel = '0, cbc_sel = '0;
  logic        ost_clr = 1'b0;
  // A: zero up/dn high, period low, cmpA up low / dn high, cmpB up toggle / dn hold
  logic [15:0] ev_act_a = 16'h395A;
  // B: zero up low / dn hold, period up high / dn hold, cmpA toggle, cmpB up high / dn low
  logic [15:0] ev_act_b = 16'h6F21;
  logic [3:0]  ost_act_a = 4'b0101, ost_act_b = 4'b0110;
  logic [3:0]  cbc_act_a = 4'b1010, cbc_act_b = 4'b1101;
  logic        pwm_a, pwm_b, ost_active, cbc_active;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  pwm_trip_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_up(cnt_up), .tez(tez), .tep(tep),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .fault_in(fault_in), .flt_en(flt_en),
    .flt_pol(flt_pol), .ost_sel(ost_sel), .cbc_sel(cbc_sel), .ost_clr(ost_clr),
    .ev_act_a(ev_act_a), .ev_act_b(ev_act_b), .ost_act_a(ost_act_a),
    .ost_act_b(ost_act_b), .cbc_act_a(cbc_act_a), .cbc_act_b(cbc_act_b),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .ost_active(ost_active), .cbc_active(cbc_active)
  );

  // {up, tez, tep, cnt, exp_a, exp_b}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 16'd0,   1'b1, 1'b0},  // R3 zero up
    {1'b1, 1'b0, 1'b0, 16'd50,  1'b1, 1'b0},  // R2 idle hold
    {1'b1, 1'b0, 1'b0, 16'd100, 1'b0, 1'b1},  // R4 cmpA up
    {1'b1, 1'b0, 1'b0, 16'd200, 1'b1, 1'b1},  // R4 cmpB up
    {1'b1, 1'b0, 1'b1, 16'd300, 1'b0, 1'b1},  // R3 period up
    {1'b0, 1'b0, 1'b0, 16'd200, 1'b0, 1'b0},  // R3 cmpB down
    {1'b0, 1'b0, 1'b0, 16'd100, 1'b1, 1'b1},  // R3 cmpA down
    {1'b0, 1'b1, 1'b0, 16'd0,   1'b1, 1'b1},  // R3 zero down
    {1'b1, 1'b0, 1'b1, 16'd100, 1'b0, 1'b1},  // R5 period over cmpA
    {1'b1, 1'b1, 1'b0, 16'd200, 1'b1, 1'b0},  // R5 zero over cmpB
    {1'b1, 1'b0, 1'b0, 16'd100, 1'b0, 1'b1},  // R2 toggle
    {1'b1, 1'b0, 1'b0, 16'd100, 1'b0, 1'b0}   // R2 toggle back
  };

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic step(input logic up, input logic z, input logic p, input logic [15:0] c);
    @(negedge clk);
    cnt_up = up; tez = z; tep = p; cnt = c;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_ab(input string req, input logic ea, input logic eb);
    chk({req, " pwm_a"}, pwm_a, ea);
    chk({req, " pwm_b"}, pwm_b, eb);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pwm_a", pwm_a, 1'b0);
    chk("R1 reset pwm_b", pwm_b, 1'b0);
    chk("R1 reset ost_active", ost_active, 1'b0);
    chk("R1 reset cbc_active", cbc_active, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17:2]);
      chk_ab($sformatf("R2/R3/R4/R5 vec%0d", i), VEC[i][1], VEC[i][0]);
    end

    // R5: compare B wins over compare A when both match
    cmp_a = 16'd150; cmp_b = 16'd150;
    step(1'b1, 1'b0, 1'b0, 16'd150);
    chk("R5 cmpB over cmpA pwm_a", pwm_a, 1'b1);
    cmp_a = 16'd100; cmp_b = 16'd200;

    // R6: disabled fault, and enabled fault at inactive level, are ignored
    ost_sel[0] = 1'b1; flt_pol[0] = 1'b1; fault_in[0] = 1'b1;
    step(1'b1, 1'b0, 1'b0, 16'd50);
    chk("R6 disabled fault ost_active", ost_active, 1'b0);
    chk("R6 disabled fault pwm_a", pwm_a, 1'b1);
    flt_en[0] = 1'b1; fault_in[0] = 1'b0;
    step(1'b1, 1'b0, 1'b0, 16'd50);
    chk("R6 inactive level ost_active", ost_active, 1'b0);

    // R7: active-low fault 1 latches one-shot trip
    flt_en[1] = 1'b1; flt_pol[1] = 1'b0; ost_sel[1] = 1'b1; fault_in[1] = 1'b0;
    step(1'b1, 1'b1, 1'b0, 16'd0);
    chk_ab("R7 ost over zero", 1'b0, 1'b1);
    chk("R7 ost_active set", ost_active, 1'b1);
    fault_in[1] = 1'b1;
    step(1'b1, 1'b1, 1'b0, 16'd0);
    chk_ab("R7 ost held after fault", 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 16'd50);
    chk_ab("R9 ost down action", 1'b0, 1'b0);
    ost_clr = 1'b1;
    step(1'b1, 1'b0, 1'b0, 16'd50);
    chk_ab("R7 clear cycle still tripped", 1'b0, 1'b1);
    chk("R7 ost_active cleared", ost_active, 1'b0);
    ost_clr = 1'b0;
    step(1'b1, 1'b1, 1'b0, 16'd0);
    chk_ab("R7 events resume", 1'b1, 1'b0);

    // R7: set wins over clear
    fault_in[1] = 1'b0; ost_clr = 1'b1;
    step(1'b1, 1'b0, 1'b0, 16'd50);
    chk("R7 set wins over clear", ost_active, 1'b1);
    fault_in[1] = 1'b1;
    step(1'b1, 1'b0, 1'b0, 16'd50);
    chk("R7 clear without fault", ost_active, 1'b0);
    ost_clr = 1'b0;
    step(1'b1, 1'b1, 1'b0, 16'd0);
    chk_ab("R7 after clear", 1'b1, 1'b0);

    // R8: cycle-by-cycle trip on fault 2
    step(1'b1, 1'b0, 1'b0, 16'd100);
    chk_ab("R4 cmpA before cbc", 1'b0, 1'b1);
    flt_en[2] = 1'b1; flt_pol[2] = 1'b1; cbc_sel[2] = 1'b1; fault_in[2] = 1'b1;
    step(1'b1, 1'b0, 1'b0, 16'd50);
    chk_ab("R8 cbc applied", 1'b1, 1'b0);
    chk("R8 cbc_active set", cbc_active, 1'b1);
    fault_in[2] = 1'b0;
    step(1'b1, 1'b0, 1'b0, 16'd200);
    chk_ab("R8 cbc held over cmpB", 1'b1, 1'b0);
    chk("R8 cbc_active held", cbc_active, 1'b1);
    step(1'b0, 1'b1, 1'b0, 16'd0);
    chk_ab("R8 zero action at release", 1'b1, 1'b0);
    chk("R8 cbc_active released", cbc_active, 1'b0);
    step(1'b1, 1'b0, 1'b0, 16'd100);
    chk_ab("R8 normal after release", 1'b0, 1'b1);

    // R9: one-shot wins over cycle-by-cycle
    fault_in[1] = 1'b0; fault_in[2] = 1'b1;
    step(1'b0, 1'b0, 1'b0, 16'd50);
    chk_ab("R9 ost over cbc", 1'b0, 1'b0);
    chk("R9 ost_active", ost_active, 1'b1);
    fault_in = '0; flt_en = '0;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule